// File: doc/BRIEF.md
# Local Countdown Timer with Vector-Table Entry

This block is the timer that sits beside a core's local interrupt controller. Software loads a start value into the initial-count register. That value goes into a down-counter, and the counter steps down once every `TICK_DIV` clock cycles. When the count runs out, the block looks at a 32-bit vector-table entry to decide what to do. The entry packs an interrupt vector, a delivery mode, a trigger-mode bit, a mask bit and a periodic-select bit.

An unmasked expiry produces a request strobe for the interrupt controller. The strobe carries the entry's vector, delivery mode and trigger bit. In periodic mode the counter re-arms from the last value written to the initial-count register. In one-shot mode it stays at zero. The current count, the initial count and the entry can all be read back at any time.

The request output is a plain one-cycle strobe. The interrupt controller beside it accepts a request in every cycle, so the block has no ready input and applies no back-pressure. A strobe is never held or repeated. The register write ports are plain enables with data and take effect at the clock edge where the enable is high.

Top module: `ltmr_top`

## Requirements
- R1: After reset the current count and the initial count read 0, no request is issued, and the entry reads 32'h0001_0000 (masked, one-shot, vector 0, mode 0).
- R2: A write of N (N > 0) to the initial count loads the current count with N and restarts the tick divider. The count then drops by one every `TICK_DIV` cycles. On expiry the request strobe is high in the cycle after the clock edge that comes N*`TICK_DIV` edges after the write edge.
- R3: The request strobe is high for exactly one cycle per expiry. During that cycle `irq_vector` equals entry bits 7:0, `irq_mode` equals entry bits 10:8, and `irq_level` equals entry bit 15 (1 = level-triggered).
- R4: When entry bit 16 (mask) is set at the expiry, no request is issued.
- R5: When entry bit 17 (periodic) is set, expiry reloads the current count from the stored initial count, whether or not the entry is masked. The next expiry follows N*`TICK_DIV` edges later.
- R6: When entry bit 17 is clear, the current count reads 0 after expiry and no further request follows until the next initial-count write.
- R7: Writing 0 to the initial count stops the timer at once, and no request is issued.
- R8: Writing the entry does not change or restart the running count. A new mask value applies to the next expiry.
- R9: Entry bits 12 (delivery status, always idle), 14, 11 and 31:18 read 0. Every other bit reads back as last written.
- R10: Writing the initial count while a count is running restarts the countdown from the new value.
- R11: The initial-count read port returns the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvt_wr_en | input | 1 | Write strobe for the vector-table entry |
| lvt_wr_data | input | 32 | Entry value to write |
| lvt_rd_data | output | 32 | Entry readback |
| icnt_wr_en | input | 1 | Write strobe for the initial count |
| icnt_wr_data | input | CNT_W | Initial count to write |
| icnt_rd_data | output | CNT_W | Initial-count readback |
| ccnt_rd_data | output | CNT_W | Current count |
| irq_valid | output | 1 | One-cycle request strobe |
| irq_vector | output | 8 | Vector carried by the request |
| irq_mode | output | 3 | Delivery mode carried by the request |
| irq_level | output | 1 | Trigger mode carried by the request (1 = level) |

## Verification
The hardest situation to reach is an entry rewrite that lands in the middle of a running count. The count has to be shown to continue without a restart, and the new mask has to govern the expiry that follows. The bench gets there with a mid-run write slot in its stimulus task. The slot fires at a chosen cycle between divider ticks. The bench then checks the current count against its tick arithmetic and checks that a strobe appears or stays absent at the exact expiry cycle. The same slot rewrites the initial count mid-run and writes zero to stop the timer.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

  // Packed vector-table entry, MSB first; field positions are decoded by the
  // interrupt controller, so they are fixed.
  typedef struct packed {
    logic [13:0] rsvd_hi;   // 31:18
    logic        periodic;  // 17
    logic        mask;      // 16
    logic        level;     // 15
    logic        rirr;      // 14
    logic        polarity;  // 13
    logic        busy;      // 12
    logic        rsvd_11;   // 11
    logic [2:0]  mode;      // 10:8
    logic [7:0]  vector;    // 7:0
  } lvt_t;

  localparam logic [31:0] LVT_RESET = 32'h0001_0000;

  // Drop bits that are read-only or reserved in this block.
  function automatic lvt_t lvt_clean(input logic [31:0] w);
    lvt_t e;
    e         = lvt_t'(w);
    e.rsvd_hi = '0;
    e.rsvd_11 = 1'b0;
    e.busy    = 1'b0;
    e.rirr    = 1'b0;
    return e;
  endfunction

endpackage

// File: rtl/ltmr_prescaler.sv
module ltmr_prescaler #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] phase;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             phase <= '0;
        else if (restart)       phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
      end

      assign tick = (phase == LAST);

      // R2
      tick_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/ltmr_lvt_reg.sv
module ltmr_lvt_reg
  import ltmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output lvt_t        entry,
  output logic [31:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     entry <= lvt_t'(LVT_RESET);
    else if (wr_en) entry <= lvt_clean(wr_data);
  end

  assign rd_data = entry;

  // R9
  status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[12] == 1'b0) && (rd_data[14] == 1'b0));

  // R8
  lvt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[17:0] == ($past(wr_data[17:0]) & 18'h3_A7FF));

endmodule

// File: rtl/ltmr_down_counter.sv
module ltmr_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] init_q,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = tick && !load && (cur == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      init_q <= '0;
    end else if (load) begin
      init_q <= load_val;
      cur    <= load_val;
    end else if (tick && (cur != '0)) begin
      if (cur == ONE) cur <= periodic ? init_q : '0;
      else            cur <= cur - ONE;
    end
  end

  // R6
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == '0 && !load) |=> cur == '0);

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur <= init_q);

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cur == ($past(periodic) ? init_q : '0));

endmodule

// File: rtl/ltmr_request.sv
module ltmr_request
  import ltmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  lvt_t       entry,
  output logic       irq_valid,
  output logic [7:0] irq_vector,
  output logic [2:0] irq_mode,
  output logic       irq_level
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_mode   <= '0;
      irq_level  <= 1'b0;
    end else begin
      irq_valid <= expire && !entry.mask;
      if (expire) begin
        irq_vector <= entry.vector;
        irq_mode   <= entry.mode;
        irq_level  <= entry.level;
      end
    end
  end

  // R4
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(entry.mask));

  // R3
  field_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vector == $past(entry.vector) && irq_level == $past(entry.level));

endmodule

// File: rtl/ltmr_top.sv
module ltmr_top
  import ltmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvt_wr_en,
  input  logic [31:0]      lvt_wr_data,
  output logic [31:0]      lvt_rd_data,
  input  logic             icnt_wr_en,
  input  logic [CNT_W-1:0] icnt_wr_data,
  output logic [CNT_W-1:0] icnt_rd_data,
  output logic [CNT_W-1:0] ccnt_rd_data,
  output logic             irq_valid,
  output logic [7:0]       irq_vector,
  output logic [2:0]       irq_mode,
  output logic             irq_level
);

  lvt_t entry;
  logic tick;
  logic expire;

  ltmr_prescaler #(.TICK_DIV(TICK_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (icnt_wr_en),
    .tick    (tick)
  );

  ltmr_lvt_reg u_lvt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (lvt_wr_en),
    .wr_data (lvt_wr_data),
    .entry   (entry),
    .rd_data (lvt_rd_data)
  );

  ltmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (icnt_wr_en),
    .load_val (icnt_wr_data),
    .tick     (tick),
    .periodic (entry.periodic),
    .cur      (ccnt_rd_data),
    .init_q   (icnt_rd_data),
    .expire   (expire)
  );

  ltmr_request u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .entry      (entry),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector),
    .irq_mode   (irq_mode),
    .irq_level  (irq_level)
  );

  // R2
  expiry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(ccnt_rd_data) == CNT_W'(1));

  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (icnt_wr_en && icnt_wr_data == '0) |=> !irq_valid);

endmodule

// File: tb/tb_ltmr_top.sv
module tb_ltmr_top;
  localparam int CLK_PERIOD = 10;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lvt_wr_en = 1'b0;
  logic [31:0] lvt_wr_data = '0;
  logic [31:0] lvt_rd_data;
  logic        icnt_wr_en = 1'b0;
  logic [31:0] icnt_wr_data = '0;
  logic [31:0] icnt_rd_data, ccnt_rd_data;
  logic        irq_valid, irq_level;
  logic [7:0]  irq_vector;
  logic [2:0]  irq_mode;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ltmr_top #(.CNT_W(32), .TICK_DIV(D)) dut (
    .clk(clk), .rst_n(rst_n),
    .lvt_wr_en(lvt_wr_en), .lvt_wr_data(lvt_wr_data), .lvt_rd_data(lvt_rd_data),
    .icnt_wr_en(icnt_wr_en), .icnt_wr_data(icnt_wr_data), .icnt_rd_data(icnt_rd_data),
    .ccnt_rd_data(ccnt_rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .irq_mode(irq_mode), .irq_level(irq_level)
  );

  // {entry, initial count}
  localparam logic [47:0] VEC [6] = '{
    {32'h0000_0041, 16'd3},
    {32'h0000_8522, 16'd2},
    {32'h0001_0030, 16'd3},
    {32'h0002_02F0, 16'd2},
    {32'h0003_8011, 16'd3},
    {32'h0000_07FF, 16'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at posedge+1, sample at posedge+1 before driving.
  task automatic run_case(input string tag, input logic [31:0] lvt0, input int n,
                          input int mid_k, input int mid_sel, input logic [31:0] mid_val,
                          input int win, input int exp_first, input int exp_cnt,
                          input logic [31:0] fields, input int cur_k, input int exp_cur);
    int first = 0;
    int cnt = 0;
    lvt_wr_en = 1'b1; lvt_wr_data = lvt0;
    @(posedge clk); #1;
    lvt_wr_en = 1'b0;
    icnt_wr_en = 1'b1; icnt_wr_data = n;
    @(posedge clk); #1;            // write edge E0
    icnt_wr_en = 1'b0;
    chk({tag, " R11 icnt readback"}, icnt_rd_data, n);
    for (int k = 1; k <= win; k++) begin
      @(posedge clk); #1;
      lvt_wr_en = 1'b0; icnt_wr_en = 1'b0;
      if (irq_valid) begin
        cnt++;
        if (first == 0) begin
          first = k;
          chk({tag, " R3 vector"}, {24'd0, irq_vector}, {24'd0, fields[7:0]});
          chk({tag, " R3 mode"}, {29'd0, irq_mode}, {29'd0, fields[10:8]});
          chk({tag, " R3 level"}, {31'd0, irq_level}, {31'd0, fields[15]});
        end
      end
      if (k == cur_k) chk({tag, " current count"}, ccnt_rd_data, exp_cur);
      if (k == mid_k) begin
        if (mid_sel == 1) begin lvt_wr_en = 1'b1; lvt_wr_data = mid_val; end
        else begin icnt_wr_en = 1'b1; icnt_wr_data = mid_val; end
      end
    end
    chk({tag, " expiry cycle"}, first, exp_first);
    chk({tag, " strobe count"}, cnt, exp_cnt);
    icnt_wr_en = 1'b1; icnt_wr_data = 0;
    @(posedge clk); #1;
    icnt_wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 current count", ccnt_rd_data, 0);
    chk("R1 initial count", icnt_rd_data, 0);
    chk("R1 strobe", {31'd0, irq_valid}, 0);
    chk("R1 entry", lvt_rd_data, 32'h0001_0000);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R9 readback masking
    lvt_wr_en = 1'b1; lvt_wr_data = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    lvt_wr_en = 1'b0;
    chk("R9 entry readback", lvt_rd_data, 32'h0003_A7FF);

    // Table walk: R2 timing, R3 fields, R4 mask, R5 periodic, R6 one-shot
    foreach (VEC[i]) begin
      logic [31:0] e;
      int n, per, msk;
      e = VEC[i][47:16];
      n = int'(VEC[i][15:0]);
      per = int'(e[17]);
      msk = int'(e[16]);
      run_case($sformatf("R2/R4/R5/R6 vec%0d", i), e, n, 0, 0, 0, 2*n*D + 2,
               msk ? 0 : n*D, msk ? 0 : (per ? 2 : 1), e, n*D, per ? n : 0);
    end

    // R7 stop by writing zero
    run_case("R7", 32'h0000_0041, 5, 2, 2, 0, 40, 0, 0, 32'h41, 30, 0);
    // R8 entry write mid-run: count unchanged, new mask applies
    run_case("R8 mask-on", 32'h0000_0041, 6, 5, 1, 32'h0001_0041, 30, 0, 0, 32'h41, 8, 4);
    run_case("R8 mask-off", 32'h0001_0055, 6, 5, 1, 32'h0000_0055, 30, 24, 1, 32'h55, 8, 4);
    // R10 restart with a new count mid-run
    run_case("R10", 32'h0000_0041, 10, 9, 2, 3, 40, 22, 1, 32'h41, 10, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule